// File: doc/BRIEF.md
# E1 Signaling Multiframe Aligner

This block sits behind an E1 frame aligner that has already found frame alignment. Once per frame the frame aligner gives it a one-cycle strobe together with the octet received in time slot 16. The block uses these octets to find the 16-frame signaling multiframe. In that multiframe, the frame whose time-slot-16 octet carries the alignment word is frame 0. After lock the block reports a locked flag and the number of the current frame within the multiframe.

The alignment word is any octet whose high four bits are zero. By default, one alignment word whose previous octet was not an alignment word is enough for lock. A strict-mode input raises the bar: a candidate then has to be followed by alignment words exactly 16 and 32 frames later. A search that runs too long without lock is abandoned. The block then sends a one-cycle resync request back to the frame aligner and starts searching again.

When the frame aligner drops its frame-sync indication, the block clears lock, the search and the timeout count. It waits there until frame sync returns.

Top module: `cas_mf_align`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mf_locked`, `resync_req` and `frame_num` are all 0.
- R2: An octet counts as an alignment word exactly when bits 7:4 are 0000. Bits 3:0 never affect the result, and an octet with any of bits 7:4 set never causes lock.
- R3: In default mode (`strict_mode`=0), a strobed alignment word whose previous strobed octet was not an alignment word sets `mf_locked` on the cycle after the strobe, with `frame_num`=0. The previous octet is tracked over every strobe, including strobes while `fas_sync` is low. Right after reset it counts as not an alignment word.
- R4: In default mode, an alignment word whose previous strobed octet was also an alignment word does not cause lock.
- R5: In strict mode, a candidate (found as in R3) leads to lock only when the octets 16 and 32 strobes later are both alignment words. Lock appears on the cycle after the third word, with `frame_num`=0. Alignment words at other positions in between are ignored.
- R6: In strict mode, a non-alignment octet 16 or 32 strobes after the candidate drops the candidate and restarts the search.
- R7: Counting from the start of a search, the 96th strobe that does not bring lock (with `fas_sync` high) produces `resync_req`=1 for exactly one cycle, on the cycle after that strobe. The search then restarts with a fresh count. `resync_req` is never high together with `mf_locked`.
- R8: If the strobe that would expire the timeout also completes lock, lock wins: `mf_locked` rises and `resync_req` stays 0.
- R9: While locked, `frame_num` advances by one, modulo 16, on each strobe. While unlocked, it is 0.
- R10: Cycles without a strobe change neither `mf_locked` nor `frame_num`, whatever value `ts16` carries.
- R11: `fas_sync`=0 clears `mf_locked` on the next cycle and holds the search and the timeout count at their start. Counting resumes once `fas_sync` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fas_sync | input | 1 | Frame alignment held by the upstream frame aligner |
| strict_mode | input | 1 | 1 selects the three-word lock criterion |
| ts_stb | input | 1 | One-cycle strobe per frame, qualifies `ts16` |
| ts16 | input | 8 | Octet received in time slot 16 of the current frame |
| mf_locked | output | 1 | Signaling multiframe lock |
| frame_num | output | 4 | Frame index within the multiframe, 0 when unlocked |
| resync_req | output | 1 | One-cycle request for a full frame resync |

## Verification
Lock and timeout expiry can both fall on the same strobe. This happens when the search has already consumed 95 fruitless strobes and the 96th carries a valid alignment word. The bench provokes it by restarting the search, sending exactly 95 non-alignment octets, then a fresh alignment word. It judges the outcome on the cycle after that strobe: lock must be set and the resync request must be absent. A second run with a non-alignment octet on the 96th strobe confirms that the request appears at that same point.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;

    localparam int MF_FRAMES = 16;
    localparam int MF_IDX_W  = $clog2(MF_FRAMES);

    typedef logic [MF_IDX_W-1:0] mf_idx_t;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCK   = 2'd2
    } mf_state_e;

    // Per-strobe observation of time slot 16
    typedef struct packed {
        logic strobe;
        logic is_word;
        logic prev_word;
    } ts16_obs_t;

    function automatic logic is_align_word(input logic [7:0] octet);
        return (octet[7:4] == 4'b0000);
    endfunction

endpackage

// File: rtl/cas_word_detect.sv
module cas_word_detect
    import cas_mf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ts_stb,
    input  logic [7:0] ts16,
    output ts16_obs_t  obs
);
    logic prev_q;
    logic word_now;

    assign word_now = is_align_word(ts16);

    // Remembers whether the last strobed octet was an alignment word
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (ts_stb) begin
            prev_q <= word_now;
        end
    end

    always_comb begin
        obs.strobe    = ts_stb;
        obs.is_word   = word_now;
        obs.prev_word = prev_q;
    end
endmodule

// File: rtl/cas_mf_timer.sv
module cas_mf_timer #(
    parameter int LIMIT = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == LAST_VAL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/cas_mf_fsm.sv
module cas_mf_fsm
    import cas_mf_pkg::*;
#(
    parameter int CONFIRM_WORDS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fas_sync,
    input  logic      strict_mode,
    input  ts16_obs_t obs,
    input  logic      tmo_last,
    output logic      searching,
    output logic      locked,
    output mf_idx_t   frame_idx,
    output logic      resync
);
    localparam int HW = (CONFIRM_WORDS > 1) ? $clog2(CONFIRM_WORDS) : 1;
    localparam logic [HW-1:0] HIT_LAST = HW'(CONFIRM_WORDS - 1);

    mf_state_e     st_q, st_n;
    mf_idx_t       pos_q, pos_n;
    logic [HW-1:0] hit_q, hit_n;
    logic          rs_q, rs_n;

    always_comb begin
        st_n  = st_q;
        pos_n = pos_q;
        hit_n = hit_q;
        rs_n  = 1'b0;
        if (!fas_sync) begin
            st_n  = ST_HUNT;
            pos_n = '0;
            hit_n = '0;
        end else if (obs.strobe) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (obs.is_word && !obs.prev_word) begin
                        st_n  = strict_mode ? ST_VERIFY : ST_LOCK;
                        pos_n = '0;
                        hit_n = '0;
                    end
                end
                ST_VERIFY: begin
                    pos_n = pos_q + mf_idx_t'(1);
                    if (pos_n == '0) begin
                        if (!obs.is_word) begin
                            st_n = ST_HUNT;
                        end else if (hit_q == HIT_LAST) begin
                            st_n = ST_LOCK;
                        end else begin
                            hit_n = hit_q + HW'(1);
                        end
                    end
                end
                ST_LOCK: begin
                    pos_n = pos_q + mf_idx_t'(1);
                end
                default: st_n = ST_HUNT;
            endcase
            // Expiry only when this strobe does not complete lock
            if (st_q != ST_LOCK && st_n != ST_LOCK && tmo_last) begin
                rs_n  = 1'b1;
                st_n  = ST_HUNT;
                pos_n = '0;
                hit_n = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_HUNT;
            pos_q <= '0;
            hit_q <= '0;
            rs_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            pos_q <= pos_n;
            hit_q <= hit_n;
            rs_q  <= rs_n;
        end
    end

    assign searching = (st_q != ST_LOCK);
    assign locked    = (st_q == ST_LOCK);
    assign frame_idx = locked ? pos_q : '0;
    assign resync    = rs_q;
endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align
    import cas_mf_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 96,
    parameter int CONFIRM_WORDS  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fas_sync,
    input  logic       strict_mode,
    input  logic       ts_stb,
    input  logic [7:0] ts16,
    output logic       mf_locked,
    output logic [3:0] frame_num,
    output logic       resync_req
);
    ts16_obs_t obs;
    logic      searching;
    logic      tmo_last;
    logic      locked;
    mf_idx_t   idx;
    logic      rs;

    cas_word_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .ts_stb (ts_stb),
        .ts16   (ts16),
        .obs    (obs)
    );

    cas_mf_timer #(.LIMIT(TIMEOUT_FRAMES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (!fas_sync || !searching),
        .tick (fas_sync && ts_stb && searching),
        .last (tmo_last)
    );

    cas_mf_fsm #(.CONFIRM_WORDS(CONFIRM_WORDS)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .fas_sync    (fas_sync),
        .strict_mode (strict_mode),
        .obs         (obs),
        .tmo_last    (tmo_last),
        .searching   (searching),
        .locked      (locked),
        .frame_idx   (idx),
        .resync      (rs)
    );

    assign mf_locked  = locked;
    assign frame_num  = 4'(idx);
    assign resync_req = rs;
endmodule

// File: rtl/cas_mf_align_chk.sv
module cas_mf_align_chk (
    input logic       clk,
    input logic       rst,
    input logic       fas_sync,
    input logic       ts_stb,
    input logic [7:0] ts16,
    input logic       mf_locked,
    input logic [3:0] frame_num,
    input logic       resync_req
);
    p_resync_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        resync_req |=> !resync_req);

    p_resync_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
        resync_req |-> !mf_locked);

    p_idx_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !mf_locked |-> (frame_num == 4'd0));

    p_idx_step_r9: assert property (@(posedge clk) disable iff (rst)
        (mf_locked && ts_stb && fas_sync) |=>
            (mf_locked && frame_num == $past(frame_num) + 4'd1));

    p_no_strobe_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!ts_stb && fas_sync) |=> ($stable(mf_locked) && $stable(frame_num)));

    p_fas_drop_r11: assert property (@(posedge clk) disable iff (rst)
        !fas_sync |=> !mf_locked);

    p_bad_word_r2: assert property (@(posedge clk) disable iff (rst)
        (!mf_locked && ts_stb && ts16[7:4] != 4'd0) |=> !mf_locked);
endmodule

bind cas_mf_align cas_mf_align_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fas_sync   (fas_sync),
    .ts_stb     (ts_stb),
    .ts16       (ts16),
    .mf_locked  (mf_locked),
    .frame_num  (frame_num),
    .resync_req (resync_req)
);

// File: tb/cas_mf_align_tb.sv
module cas_mf_align_tb_top;
    localparam int TMO = 96;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fas_sync = 1'b0;
    logic       strict_mode = 1'b0;
    logic       ts_stb = 1'b0;
    logic [7:0] ts16 = 8'hFF;
    logic       mf_locked;
    logic [3:0] frame_num;
    logic       resync_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cas_mf_align #(.TIMEOUT_FRAMES(TMO), .CONFIRM_WORDS(2)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .fas_sync    (fas_sync),
        .strict_mode (strict_mode),
        .ts_stb      (ts_stb),
        .ts16        (ts16),
        .mf_locked   (mf_locked),
        .frame_num   (frame_num),
        .resync_req  (resync_req)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input int lk, input int fn, input int rs);
        chk(mf_locked == lk[0], {tag, " locked"}, int'(mf_locked), lk);
        chk(frame_num == fn[3:0], {tag, " frame_num"}, int'(frame_num), fn);
        chk(resync_req == rs[0], {tag, " resync"}, int'(resync_req), rs);
    endtask

    // One strobe; returns at the negedge after the capturing posedge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        ts_stb = 1'b1;
        ts16   = b;
        @(negedge clk);
        ts_stb = 1'b0;
        ts16   = 8'hFF;
    endtask

    // Restart search; the octet strobed during the gap sets the "previous" word
    task automatic restart(input logic [7:0] gap_octet);
        @(negedge clk);
        fas_sync = 1'b0;
        send(gap_octet);
        fas_sync = 1'b1;
    endtask

    task automatic send_fillers(input int n);
        for (int i = 0; i < n; i++) send(8'h9C);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_out("R1 in reset", 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_out("R1 after reset", 0, 0, 0);
        fas_sync = 1'b1;

        // R3/R2/R9: default lock after k fillers, every low nibble
        for (int k = 0; k < 3; k++) begin
            for (int nib = 0; nib < 16; nib++) begin
                restart(8'hF3);
                send_fillers(k);
                chk_out("R2 pre-lock", 0, 0, 0);
                send({4'h0, nib[3:0]});
                chk_out("R3 lock", 1, 0, 0);
                if (nib == 5) begin
                    for (int j = 1; j <= 20; j++) begin
                        send((j % 3 == 0) ? 8'h00 : 8'h7E);
                        chk_out("R9 count", 1, j % 16, 0);
                    end
                end
            end
        end

        // R2: every high nibble other than 0 is not a word
        for (int hi = 1; hi < 16; hi++) begin
            restart(8'hF0);
            send({hi[3:0], 4'h0});
            chk_out("R2 nonword", 0, 0, 0);
        end

        // R4: word after word does not lock
        restart(8'h05);
        send(8'h03);
        chk_out("R4 word after word", 0, 0, 0);
        send(8'hA0);
        chk_out("R4 filler", 0, 0, 0);
        send(8'h0C);
        chk_out("R3 after filler", 1, 0, 0);

        // R10: no strobe, no change
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ts16 = 8'(i * 37);
        end
        @(negedge clk);
        chk_out("R10 hold", 1, 0, 0);

        // R11: fas drop clears lock, timer restarts
        @(negedge clk);
        fas_sync = 1'b0;
        @(negedge clk);
        chk_out("R11 fas drop", 0, 0, 0);
        fas_sync = 1'b1;
        send_fillers(TMO - 1);
        chk_out("R11 count restarted", 0, 0, 0);

        // R7: timeout on 96th fruitless strobe
        restart(8'hF1);
        send_fillers(TMO - 1);
        chk_out("R7 before expiry", 0, 0, 0);
        send(8'h88);
        chk_out("R7 expiry", 0, 0, 1);
        @(negedge clk);
        chk_out("R7 one cycle", 0, 0, 0);
        send_fillers(TMO - 1);
        chk_out("R7 fresh count", 0, 0, 0);
        send(8'h88);
        chk_out("R7 second expiry", 0, 0, 1);

        // R8: lock on the expiry strobe wins
        restart(8'hF1);
        send_fillers(TMO - 1);
        send(8'h02);
        chk_out("R8 lock beats timeout", 1, 0, 0);

        // R5: strict three-word lock, stray word in between ignored
        strict_mode = 1'b1;
        restart(8'hEE);
        send(8'h0B);
        chk_out("R5 candidate", 0, 0, 0);
        send_fillers(6);
        send(8'h00);
        send_fillers(8);
        send(8'h04);
        chk_out("R5 second word", 0, 0, 0);
        send_fillers(15);
        send(8'h0F);
        chk_out("R5 strict lock", 1, 0, 0);
        send(8'h55);
        chk_out("R5 count", 1, 1, 0);

        // R6: mismatch at +16 restarts search
        restart(8'hEE);
        send(8'h01);
        send_fillers(15);
        send(8'h40);
        chk_out("R6 mismatch16", 0, 0, 0);
        send_fillers(15);
        send(8'h02);
        chk_out("R6 old candidate gone", 0, 0, 0);
        send_fillers(15);
        send(8'h03);
        send_fillers(15);
        send(8'h00);
        chk_out("R6 relock", 1, 0, 0);

        // R6: mismatch at +32
        restart(8'hEE);
        send(8'h01);
        send_fillers(15);
        send(8'h01);
        send_fillers(15);
        send(8'hFF);
        chk_out("R6 mismatch32", 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule